// File: doc/BRIEF.md
# Presence-Tagged Producer/Consumer Memory

This block is a small word-addressed store in which every word carries one presence flag next to its data. The flag is set while the word holds a valid value and clear while it is empty. Each word therefore works as its own meeting point between a producer and a consumer. A consumer that asks for a word that is already present gets the value just like a plain memory read. A consumer that asks for a word that is still empty is held back until a producer writes that word. Stale data is never returned.

The consumer side is a request handshake: `take_valid` with `take_addr`, accepted when `take_ready` is high. The answer comes back as a one-cycle pulse on `give_valid` with `give_data`. The read side is a two-state machine. In `S_IDLE` it accepts requests. A request that finds its word present takes the `IDLE_HIT` transition, stays in `S_IDLE` and answers on the next cycle. A request that finds its word empty takes the `IDLE_MISS` transition into `S_WAIT`. There it keeps the address registered and holds `take_ready` low. When the producer fills that word, the `WAIT_RELEASE` transition returns the machine to `S_IDLE` and answers. While the machine waits without a fill, it takes the `WAIT_HOLD` self-loop.

The producer writes through `put_en`/`put_addr`/`put_data`. A write to a word that is already full is refused and reported on `put_err`. A clear command (`wipe_en`/`wipe_addr`) marks a word empty again so that it can be reused in the next round. Writes and clears never wait on the read side, so work that only moves addresses around is never held up by a stalled consumer.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every word is empty, `take_ready` is 1, `give_valid` is 0 and `put_err` is 0. A first request to any word therefore stalls.
- R2: A request accepted at a clock edge to a word whose flag is set raises `give_valid` for exactly the following cycle, with that word's stored data. The flag stays set, so repeated reads return the same value.
- R3: A request accepted to an empty word moves the reader to `S_WAIT`. From the next cycle on, `take_ready` is 0 and `give_valid` stays 0 until the word is filled, and the waiting address is held.
- R4: A write to an empty word stores the data and sets the flag. If a request is waiting on that address, `give_valid` is 1 in the cycle after the write edge with the written data, and `take_ready` is 1 again in that cycle.
- R5: While a request is waiting, writes and clears to other addresses are carried out at once and do not release it.
- R6: A write to a word whose flag is already set does not change the stored data. It raises `put_err` for exactly the cycle after the write edge.
- R7: A clear makes the addressed word empty. A later request to it stalls, and the next write to it is accepted without error.
- R8: A request accepted in the same cycle as a write to the same empty word completes in the next cycle with the written data, and never enters `S_WAIT`.
- R9: When a clear and a write name the same address in the same cycle, the write is dropped: nothing is stored, `put_err` stays 0, and the word ends up empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| take_valid | input | 1 | Consumer request present |
| take_addr | input | ADDR_W | Word the consumer wants |
| take_ready | output | 1 | Request accepted at this edge when high together with take_valid |
| give_valid | output | 1 | One-cycle pulse: give_data holds a read result |
| give_data | output | DATA_W | Read result |
| put_en | input | 1 | Producer write strobe |
| put_addr | input | ADDR_W | Word to fill |
| put_data | input | DATA_W | Value to store |
| put_err | output | 1 | Pulse: the previous write hit a full word and was refused |
| wipe_en | input | 1 | Clear strobe |
| wipe_addr | input | ADDR_W | Word to mark empty |

## Verification
The hardest situations to reach are a consumer parked in `S_WAIT` and the two same-cycle collisions: a request and a fill to the same empty word, and a clear and a fill to the same word. The stimulus first parks a read on a word that is empty after reset. It then sends unrelated writes and clears while the read is parked and checks that the port stays closed, and only then fills the awaited word. For the collisions, the bench drives both strobes inside one cycle. It then probes the outcome through later requests: a request that stalls shows that the word is empty, and a request that answers shows the stored value.

// File: rtl/fe_pkg.sv
package fe_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } rd_state_e;
endpackage

// File: rtl/fe_presence.sv
module fe_presence #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_full,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_full
);
    logic [DEPTH-1:0] full_q;
    logic             fresh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= '0;
            fresh_q <= 1'b1;
        end else begin
            fresh_q <= 1'b0;
            if (set_en) full_q[set_addr] <= 1'b1;
            if (clr_en) full_q[clr_addr] <= 1'b0;
        end
    end

    assign look_full = full_q[look_addr];
    assign chk_full  = full_q[chk_addr];

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fresh_q |-> (full_q == '0)); // R1
    AST_SET_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !full_q[set_addr]); // R6
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !full_q[$past(clr_addr)]); // R7
endmodule

// File: rtl/fe_store.sv
module fe_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fe_read_fsm.sv
module fe_read_fsm
    import fe_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [ADDR_W-1:0] look_addr,
    input  logic              look_full,
    input  logic [DATA_W-1:0] look_data,
    input  logic              byp_en,
    input  logic [ADDR_W-1:0] byp_addr,
    input  logic [DATA_W-1:0] byp_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    rd_state_e         state_q, state_d;
    logic [ADDR_W-1:0] pend_q;
    logic              hit, fire;
    logic [DATA_W-1:0] hit_data;

    always_comb begin
        req_ready = (state_q == S_IDLE);
        look_addr = (state_q == S_IDLE) ? req_addr : pend_q;
        hit       = look_full || (byp_en && (byp_addr == look_addr));
        hit_data  = look_full ? look_data : byp_data;
        state_d   = state_q;
        fire      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (hit) fire = 1'b1;           // IDLE_HIT
                    else     state_d = S_WAIT;      // IDLE_MISS
                end
            end
            S_WAIT: begin
                if (hit) begin                      // WAIT_RELEASE
                    fire    = 1'b1;
                    state_d = S_IDLE;
                end                                 // else WAIT_HOLD
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_valid && !hit) pend_q <= req_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= fire;
            if (fire) rsp_data <= hit_data;
        end
    end

    AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(state_q == S_WAIT))); // R2
    AST_WAIT_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT) |=> (state_q == S_IDLE || $stable(pend_q))); // R3
    AST_WAIT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !hit) |=> (!req_ready && !rsp_valid)); // R3
    AST_FILL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && byp_en && byp_addr == pend_q) |=> (rsp_valid && req_ready)); // R4
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_valid,
    input  logic [ADDR_W-1:0] take_addr,
    output logic              take_ready,
    output logic              give_valid,
    output logic [DATA_W-1:0] give_data,
    input  logic              put_en,
    input  logic [ADDR_W-1:0] put_addr,
    input  logic [DATA_W-1:0] put_data,
    output logic              put_err,
    input  logic              wipe_en,
    input  logic [ADDR_W-1:0] wipe_addr
);
    logic              put_clash, put_live, put_full, put_store;
    logic [ADDR_W-1:0] look_addr;
    logic              look_full;
    logic [DATA_W-1:0] look_data;

    assign put_clash = wipe_en && (wipe_addr == put_addr);
    assign put_live  = put_en && !put_clash;
    assign put_store = put_live && !put_full;

    always_ff @(posedge clk) begin
        if (!rst_n) put_err <= 1'b0;
        else        put_err <= put_live && put_full;
    end

    fe_presence #(.ADDR_W(ADDR_W)) pres_i (
        .clk(clk), .rst_n(rst_n),
        .set_en(put_store), .set_addr(put_addr),
        .clr_en(wipe_en), .clr_addr(wipe_addr),
        .look_addr(look_addr), .look_full(look_full),
        .chk_addr(put_addr), .chk_full(put_full)
    );

    fe_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .we(put_store), .waddr(put_addr), .wdata(put_data),
        .raddr(look_addr), .rdata(look_data)
    );

    fe_read_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rd_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(take_valid), .req_addr(take_addr), .req_ready(take_ready),
        .look_addr(look_addr), .look_full(look_full), .look_data(look_data),
        .byp_en(put_store), .byp_addr(put_addr), .byp_data(put_data),
        .rsp_valid(give_valid), .rsp_data(give_data)
    );

    AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        put_err |-> $past(put_en)); // R6
    AST_CLASH_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (put_en && put_clash) |=> !put_err); // R9
endmodule

// File: tb/fe_sync_mem_tb_top.sv
`timescale 1ns/1ps
module fe_sync_mem_tb_top;
    localparam int AW = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          take_valid = 1'b0;
    logic [AW-1:0] take_addr = '0;
    logic          take_ready, give_valid, put_err;
    logic [DW-1:0] give_data;
    logic          put_en = 1'b0;
    logic [AW-1:0] put_addr = '0;
    logic [DW-1:0] put_data = '0;
    logic          wipe_en = 1'b0;
    logic [AW-1:0] wipe_addr = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] sb_d[$];
    string         sb_t[$];

    always #4 clk = ~clk;

    fe_sync_mem #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .take_valid(take_valid), .take_addr(take_addr), .take_ready(take_ready),
        .give_valid(give_valid), .give_data(give_data),
        .put_en(put_en), .put_addr(put_addr), .put_data(put_data), .put_err(put_err),
        .wipe_en(wipe_en), .wipe_addr(wipe_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    // monitor: pops the scoreboard on every response
    always @(negedge clk) begin
        if (rst_n && give_valid) begin
            if (sb_d.size() == 0) begin
                checks++; errors++;
                $display("FAIL unexpected response: got %0h expected none", give_data);
            end else begin
                automatic logic [DW-1:0] e = sb_d.pop_front();
                automatic string t = sb_t.pop_front();
                chk(t, give_data, e);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic exp_err, input string tag);
        put_en = 1'b1; put_addr = a; put_data = d;
        cyc();
        put_en = 1'b0;
        chk(tag, put_err, exp_err);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        sb_d.push_back(exp); sb_t.push_back(tag);
        take_valid = 1'b1; take_addr = a;
        cyc();
        take_valid = 1'b0;
    endtask

    task automatic wipe(input logic [AW-1:0] a);
        wipe_en = 1'b1; wipe_addr = a;
        cyc();
        wipe_en = 1'b0;
    endtask

    task automatic stalled(input string tag);
        @(negedge clk);
        chk(tag, take_ready, 1'b0);
        chk(tag, give_valid, 1'b0);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", take_ready, 1'b1);
        chk("R1 give_valid", give_valid, 1'b0);
        chk("R1 put_err", put_err, 1'b0);

        // R1/R3: word 3 is empty after reset, read parks
        rd(4'd3, 16'hA5A5, "R4 released data");
        stalled("R1 empty stall");
        stalled("R3 stall");
        // R5: unrelated write and clear while parked
        wr(4'd5, 16'h0505, 1'b0, "R5 side write err");
        wipe(4'd6);
        stalled("R5 still stalled");
        // R4: fill the awaited word
        wr(4'd3, 16'hA5A5, 1'b0, "R4 fill err");
        @(negedge clk);
        chk("R4 ready back", take_ready, 1'b1);

        // R2: hits, repeated reads keep the value
        rd(4'd5, 16'h0505, "R2 hit r5_");
        rd(4'd3, 16'hA5A5, "R2 hit again");
        rd(4'd3, 16'hA5A5, "R2 hit third");
        cyc();

        // R6: write to full word refused
        wr(4'd3, 16'h1111, 1'b1, "R6 err pulse");
        cyc();
        chk("R6 err one cycle", put_err, 1'b0);
        rd(4'd3, 16'hA5A5, "R6 data kept");
        cyc();

        // R7: clear then reuse
        wipe(4'd3);
        rd(4'd3, 16'h2222, "R7 refill data");
        stalled("R7 stall after clear");
        wr(4'd3, 16'h2222, 1'b0, "R7 refill err");
        cyc();

        // R8: read and fill same cycle
        sb_d.push_back(16'h3C3C); sb_t.push_back("R8 same-cycle data");
        take_valid = 1'b1; take_addr = 4'd9;
        put_en = 1'b1; put_addr = 4'd9; put_data = 16'h3C3C;
        cyc();
        take_valid = 1'b0; put_en = 1'b0;
        chk("R8 err", put_err, 1'b0);
        @(negedge clk);
        chk("R8 no wait", take_ready, 1'b1);
        cyc();

        // R9: clear and write clash
        wr(4'd10, 16'h4444, 1'b0, "R9 prefill");
        wipe_en = 1'b1; wipe_addr = 4'd10;
        put_en = 1'b1; put_addr = 4'd10; put_data = 16'h7777;
        cyc();
        wipe_en = 1'b0; put_en = 1'b0;
        chk("R9 no err", put_err, 1'b0);
        rd(4'd10, 16'h8888, "R9 later data");
        stalled("R9 word empty");
        wr(4'd10, 16'h8888, 1'b0, "R9 refill err");
        repeat (3) cyc();

        chk("R2 scoreboard drained", sb_d.size(), 0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog R3: got hang expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule